// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block is the register file in a host bridge that controls the legacy memory window below 1 MB. Configuration writes arrive byte-addressed, each with an offset, up to four data bytes and a byte count. The block keeps only the bytes that control routing. These are seven attribute bytes starting at offset 0x59 and the system-memory control byte at offset 0x72. From them it produces a 2-bit access attribute for the 64 KB region at 0xF0000 and for each of twelve 16 KB regions from 0xC0000 to 0xEFFFF. It also produces a flag that says whether the 128 KB window at 0xA0000 is routed to the protected system-management memory.

The routing outputs are registered. They are recomputed only when a write touches a controlling byte, or when the processor's system-management-mode input changes value. A combinational lookup port takes a physical address and returns the attribute that currently governs it. The memory datapath is not part of this block. Neither is the bus protocol that carries the configuration writes.

Top module: `legacy_attr_decoder`

## Requirements
- R1: A write carries `cfg_len` bytes, and only 1, 2 and 4 are accepted; any other value writes nothing. Byte k (bits 8k+7:8k of `cfg_wdata`) goes to offset `cfg_off`+k. Bytes whose offset would pass 0xFF are dropped and do not wrap.
- R2: After reset, all attribute bytes read as 0x00 and the control byte reads as 0x02. As a result, every attribute output is 00 and `smram_vis` is 0.
- R3: `hi_attr` (the region 0xF0000–0xFFFFF) is bits 5:4 of byte 0x59.
- R4: Segment i (0 to 11) covers 0xC0000+i·0x4000 for 16 KB. Its attribute is read from byte 0x5A+(i>>1), at bit 4·(i&1) and the bit above it. It appears at `seg_attr[2i+1:2i]`.
- R5: `smram_vis` is 1 when bit 6 of byte 0x72 is set. It is also 1 when `smm_active` is 1 and bit 3 of byte 0x72 is set. Otherwise it is 0.
- R6: The outputs are recomputed only in two cases. The first is a write that covers byte 0x72 or any byte in 0x59–0x5F. The second is a change in the value of `smm_active`. A write to a nearby offset that is not one of these bytes leaves every output unchanged.
- R7: Suppose a triggering write or a change of `smm_active` is sampled at rising edge N. The outputs keep their old values after edge N and show the new values after edge N+1.
- R8: The attribute code is 00 for no access, 01 for read-only, 10 for write-only and 11 for read/write. `lk_attr` returns `hi_attr` for addresses 0xF0000–0xFFFFF and the segment attribute for 0xC0000–0xEFFFF. It returns 00 for every other address, including 0xA0000–0xBFFFF.
- R9: Only the eight controlling bytes are stored. A write to any other offset has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_off | input | 8 | Byte offset of the first written byte |
| cfg_len | input | 3 | Number of bytes written (1, 2 or 4) |
| cfg_wdata | input | 32 | Write data, byte k in bits 8k+7:8k |
| smm_active | input | 1 | Processor is in system-management mode |
| lk_addr | input | 32 | Physical address to look up |
| lk_attr | output | 2 | Attribute governing `lk_addr` |
| hi_attr | output | 2 | Attribute of region 0xF0000–0xFFFFF |
| seg_attr | output | 24 | Attributes of the twelve 16 KB segments |
| smram_vis | output | 1 | 0xA0000 window routed to system-management memory |

## Verification
The hardest case to reach from the ports is a multi-byte write that only partly overlaps the controlling bytes. One example is a 4-byte write at 0x58, where the first byte must be dropped and the other three must land in the attribute bytes. Another is a 2-byte write at 0x5F, where only one byte counts. A third is a write near 0xFF, whose upper bytes must vanish. The vector table drives these straddling writes on purpose and then reads the result through the lookup port.

The system-management path needs its own directed sequence. It first sets the gating bit while the mode input is low. It then toggles the input and samples at both the first and the second edge afterwards, which checks the one-cycle recompute latency independently of configuration writes.

// File: rtl/lmad_pkg.sv
package lmad_pkg;

   typedef enum logic [1:0] {
      ATTR_NONE = 2'b00,
      ATTR_RO   = 2'b01,
      ATTR_WO   = 2'b10,
      ATTR_RW   = 2'b11
   } attr_e;

   // Field 0 is the 64 KB top region; field 1+i is 16 KB segment i.
   function automatic int field_byte(input int f);
      return (f == 0) ? 0 : 1 + ((f - 1) >> 1);
   endfunction

   function automatic int field_bit(input int f);
      return (f == 0) ? 4 : 4 * ((f - 1) & 1);
   endfunction

endpackage

// File: rtl/lmad_cfg_regs.sv
module lmad_cfg_regs #(
   parameter int          LANES      = 4,
   parameter int          LEN_W      = 3,
   parameter int          NUM_FLD    = 13,
   parameter logic [7:0]  ATTR_BASE  = 8'h59,
   parameter int          ATTR_BYTES = 7,
   parameter logic [7:0]  CTRL_OFF   = 8'h72,
   parameter logic [7:0]  CTRL_RST   = 8'h02,
   parameter int          FORCE_BIT  = 6,
   parameter int          GATE_BIT   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [7:0]         wr_off,
   input  logic [LEN_W-1:0]   wr_len,
   input  logic [LANES*8-1:0] wr_data,
   output logic [1:0]         fld [NUM_FLD],
   output logic               ctrl_force,
   output logic               ctrl_gate,
   output logic               hit
);
   import lmad_pkg::*;

   localparam logic [8:0] ATTR_LO = {1'b0, ATTR_BASE};
   localparam logic [8:0] ATTR_HI = {1'b0, ATTR_BASE} + 9'(ATTR_BYTES - 1);
   localparam logic [8:0] CTRL_A  = {1'b0, CTRL_OFF};

   logic [8:0]       lane_addr [LANES];
   logic [7:0]       lane_byte [LANES];
   logic [LANES-1:0] lane_act;
   logic             len_ok;

   always_comb begin
      len_ok = $onehot(wr_len) && (wr_len <= LEN_W'(LANES));
      hit    = 1'b0;
      for (int k = 0; k < LANES; k++) begin
         lane_addr[k] = {1'b0, wr_off} + 9'(k);
         lane_byte[k] = wr_data[8*k +: 8];
         lane_act[k]  = wr_en && len_ok && (LEN_W'(k) < wr_len) && !lane_addr[k][8];
         if (lane_act[k] && (((lane_addr[k] >= ATTR_LO) && (lane_addr[k] <= ATTR_HI))
                             || (lane_addr[k] == CTRL_A)))
            hit = 1'b1;
      end
   end

   for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
      localparam logic [8:0] FADDR = ATTR_LO + 9'(field_byte(f));
      localparam int         FBIT  = field_bit(f);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fld[f] <= ATTR_NONE;
         end else begin
            for (int k = 0; k < LANES; k++)
               if (lane_act[k] && lane_addr[k] == FADDR)
                  fld[f] <= lane_byte[k][FBIT +: 2];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_force <= CTRL_RST[FORCE_BIT];
         ctrl_gate  <= CTRL_RST[GATE_BIT];
      end else begin
         for (int k = 0; k < LANES; k++)
            if (lane_act[k] && lane_addr[k] == CTRL_A) begin
               ctrl_force <= lane_byte[k][FORCE_BIT];
               ctrl_gate  <= lane_byte[k][GATE_BIT];
            end
      end
   end

endmodule

// File: rtl/lmad_map.sv
module lmad_map #(
   parameter int NUM_SEG = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               recalc,
   input  logic               smm_q,
   input  logic               ctrl_force,
   input  logic               ctrl_gate,
   input  logic [1:0]         fld [NUM_SEG+1],
   output logic [1:0]         hi_attr,
   output logic [NUM_SEG*2-1:0] seg_attr,
   output logic               smram_vis
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_attr   <= '0;
         smram_vis <= 1'b0;
      end else if (recalc) begin
         hi_attr   <= fld[0];
         smram_vis <= ctrl_force | (smm_q & ctrl_gate);
      end
   end

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
      always_ff @(posedge clk) begin
         if (!rst_n)
            seg_attr[2*i +: 2] <= '0;
         else if (recalc)
            seg_attr[2*i +: 2] <= fld[i+1];
      end
   end

endmodule

// File: rtl/lmad_lookup.sv
module lmad_lookup #(
   parameter int              ADDR_W    = 32,
   parameter int              NUM_SEG   = 12,
   parameter int              SEG_SHIFT = 14,
   parameter logic [31:0]     SEG_BASE  = 32'h000C_0000,
   parameter logic [31:0]     TOP_BASE  = 32'h000F_0000,
   parameter logic [31:0]     TOP_END   = 32'h0010_0000
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [1:0]           hi_attr,
   input  logic [NUM_SEG*2-1:0] seg_attr,
   output logic [1:0]           attr
);
   import lmad_pkg::*;

   localparam int IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;
   localparam logic [ADDR_W-1:0] S_LO = ADDR_W'(SEG_BASE);
   localparam logic [ADDR_W-1:0] S_HI = ADDR_W'(SEG_BASE) + ADDR_W'(NUM_SEG << SEG_SHIFT);
   localparam logic [ADDR_W-1:0] T_LO = ADDR_W'(TOP_BASE);
   localparam logic [ADDR_W-1:0] T_HI = ADDR_W'(TOP_END);

   logic [ADDR_W-1:0] rel;
   logic [IDX_W-1:0]  idx;

   always_comb begin
      rel  = addr - S_LO;
      idx  = rel[SEG_SHIFT +: IDX_W];
      attr = ATTR_NONE;
      if (addr >= T_LO && addr < T_HI) begin
         attr = hi_attr;
      end else if (addr >= S_LO && addr < S_HI) begin
         for (int i = 0; i < NUM_SEG; i++)
            if (idx == IDX_W'(i)) attr = seg_attr[2*i +: 2];
      end
   end

endmodule

// File: rtl/legacy_attr_decoder.sv
module legacy_attr_decoder #(
   parameter int          ADDR_W     = 32,
   parameter int          DATA_W     = 32,
   parameter int          LEN_W      = 3,
   parameter int          NUM_SEG    = 12,
   parameter int          SEG_SHIFT  = 14,
   parameter logic [7:0]  ATTR_BASE  = 8'h59,
   parameter int          ATTR_BYTES = 7,
   parameter logic [7:0]  CTRL_OFF   = 8'h72,
   parameter logic [7:0]  CTRL_RST   = 8'h02,
   parameter int          FORCE_BIT  = 6,
   parameter int          GATE_BIT   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [7:0]           cfg_off,
   input  logic [LEN_W-1:0]     cfg_len,
   input  logic [DATA_W-1:0]    cfg_wdata,
   input  logic                 smm_active,
   input  logic [ADDR_W-1:0]    lk_addr,
   output logic [1:0]           lk_attr,
   output logic [1:0]           hi_attr,
   output logic [NUM_SEG*2-1:0] seg_attr,
   output logic                 smram_vis
);
   import lmad_pkg::*;

   localparam int LANES   = DATA_W / 8;
   localparam int NUM_FLD = NUM_SEG + 1;

   if (DATA_W % 8 != 0 || LANES < 1)
      begin : g_bad_data $error("DATA_W must be a whole number of bytes"); end
   if ((1 << (LEN_W - 1)) < LANES)
      begin : g_bad_len $error("LEN_W too narrow for the lane count"); end
   if (field_byte(NUM_SEG) >= ATTR_BYTES)
      begin : g_bad_fld $error("attribute bytes cannot hold all segments"); end
   if (ADDR_W < 21)
      begin : g_bad_addr $error("ADDR_W must reach the 1 MB boundary"); end

   logic [1:0] fld [NUM_FLD];
   logic       ctrl_force, ctrl_gate, hit;
   logic       smm_q, recalc_q;

   lmad_cfg_regs #(
      .LANES(LANES), .LEN_W(LEN_W), .NUM_FLD(NUM_FLD),
      .ATTR_BASE(ATTR_BASE), .ATTR_BYTES(ATTR_BYTES),
      .CTRL_OFF(CTRL_OFF), .CTRL_RST(CTRL_RST),
      .FORCE_BIT(FORCE_BIT), .GATE_BIT(GATE_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_off(cfg_off),
      .wr_len(cfg_len), .wr_data(cfg_wdata), .fld(fld),
      .ctrl_force(ctrl_force), .ctrl_gate(ctrl_gate), .hit(hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smm_q    <= 1'b0;
         recalc_q <= 1'b0;
      end else begin
         smm_q    <= smm_active;
         recalc_q <= hit | (smm_active != smm_q);
      end
   end

   lmad_map #(.NUM_SEG(NUM_SEG)) u_map (
      .clk(clk), .rst_n(rst_n), .recalc(recalc_q), .smm_q(smm_q),
      .ctrl_force(ctrl_force), .ctrl_gate(ctrl_gate), .fld(fld),
      .hi_attr(hi_attr), .seg_attr(seg_attr), .smram_vis(smram_vis)
   );

   lmad_lookup #(
      .ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .SEG_SHIFT(SEG_SHIFT)
   ) u_lookup (
      .addr(lk_addr), .hi_attr(hi_attr), .seg_attr(seg_attr), .attr(lk_attr)
   );

endmodule

// File: rtl/legacy_attr_decoder_chk.sv
module legacy_attr_decoder_chk #(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 3,
   parameter int NUM_SEG = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_wr,
   input logic [LEN_W-1:0]     cfg_len,
   input logic                 smm_active,
   input logic                 smm_q,
   input logic                 recalc_q,
   input logic                 ctrl_force,
   input logic                 ctrl_gate,
   input logic [ADDR_W-1:0]    lk_addr,
   input logic [1:0]           lk_attr,
   input logic [1:0]           hi_attr,
   input logic [NUM_SEG*2-1:0] seg_attr,
   input logic                 smram_vis
);
   localparam logic [ADDR_W-1:0] LEGACY_LO = ADDR_W'(32'h000C_0000);
   localparam logic [ADDR_W-1:0] LEGACY_HI = ADDR_W'(32'h0010_0000);

   a_r6_hold_without_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      !recalc_q |=> $stable({hi_attr, seg_attr, smram_vis}));

   a_r5_smram_rule: assert property (@(posedge clk) disable iff (!rst_n)
      recalc_q |=> smram_vis == ($past(ctrl_force) || ($past(smm_q) && $past(ctrl_gate))));

   a_r7_smm_change_triggers: assert property (@(posedge clk) disable iff (!rst_n)
      (smm_active != smm_q) |=> recalc_q);

   a_r1_bad_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !(cfg_len == 1 || cfg_len == 2 || cfg_len == 4))
      |=> $stable({ctrl_force, ctrl_gate}));

   a_r8_outside_is_none: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_addr < LEGACY_LO || lk_addr >= LEGACY_HI) |-> lk_attr == 2'b00);

endmodule

bind legacy_attr_decoder legacy_attr_decoder_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_SEG(NUM_SEG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_len(cfg_len),
   .smm_active(smm_active), .smm_q(smm_q), .recalc_q(recalc_q),
   .ctrl_force(ctrl_force), .ctrl_gate(ctrl_gate),
   .lk_addr(lk_addr), .lk_attr(lk_attr), .hi_attr(hi_attr),
   .seg_attr(seg_attr), .smram_vis(smram_vis)
);

// File: tb/tb_legacy_attr_decoder.sv
module tb_legacy_attr_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_off = '0;
   logic [2:0]  cfg_len = '0;
   logic [31:0] cfg_wdata = '0;
   logic        smm_active = 1'b0;
   logic [31:0] lk_addr = '0;
   logic [1:0]  lk_attr;
   logic [1:0]  hi_attr;
   logic [23:0] seg_attr;
   logic        smram_vis;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   legacy_attr_decoder dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off),
      .cfg_len(cfg_len), .cfg_wdata(cfg_wdata), .smm_active(smm_active),
      .lk_addr(lk_addr), .lk_attr(lk_attr), .hi_attr(hi_attr),
      .seg_attr(seg_attr), .smram_vis(smram_vis)
   );

   typedef struct packed {
      logic [7:0]  off;
      logic [2:0]  len;
      logic [31:0] data;
      logic [31:0] la;
      logic [1:0]  ea;
      logic        ev;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{8'h59, 3'd1, 32'h0000_0030, 32'h000F_8000, 2'd3, 1'b0},
      '{8'h5A, 3'd2, 32'h0000_2113, 32'h000C_4000, 2'd1, 1'b0},
      '{8'h5C, 3'd4, 32'h3210_0302, 32'h000E_C000, 2'd3, 1'b0},
      '{8'h58, 3'd4, 32'h1122_10FF, 32'h000F_0000, 2'd1, 1'b0},
      '{8'h70, 3'd4, 32'h0040_0000, 32'h000A_0000, 2'd0, 1'b1},
      '{8'hFE, 3'd4, 32'hAABB_CCDD, 32'h000C_C000, 2'd1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive one write; returns at the negedge after the sampling edge.
   task automatic cfg_write(input logic [7:0] off, input logic [2:0] len, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_off = off; cfg_len = len; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic look(input string req, input logic [31:0] a, input logic [1:0] exp);
      lk_addr = a;
      #1;
      chk(req, 32'(lk_attr), 32'(exp));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2 hi_attr", 32'(hi_attr), 0);
      chk("R2 seg_attr", 32'(seg_attr), 0);
      chk("R2 smram_vis", 32'(smram_vis), 0);
      rst_n = 1'b1;
      @(negedge clk);
      look("R2 lookup after reset", 32'h000F_0000, 2'd0);

      // Vector table: R1 lanes/straddles, R3/R4 decode, R5 force bit, R8 lookup
      foreach (VEC[i]) begin
         cfg_write(VEC[i].off, VEC[i].len, VEC[i].data);
         @(negedge clk);
         look($sformatf("R8 vector %0d lookup", i), VEC[i].la, VEC[i].ea);
         chk($sformatf("R5 vector %0d smram_vis", i), 32'(smram_vis), 32'(VEC[i].ev));
      end
      chk("R3 hi_attr after straddling write", 32'(hi_attr), 1);
      chk("R4 full segment vector", 32'(seg_attr), 32'h00E4_325A);

      // R8: lookup boundaries
      look("R8 below window", 32'h0009_FFFF, 2'd0);
      look("R8 smram window not decoded", 32'h000B_FFFF, 2'd0);
      look("R8 first segment", 32'h000C_0000, 2'd2);
      look("R8 last segment", 32'h000E_FFFF, 2'd3);
      look("R8 above 1MB", 32'h0010_0000, 2'd0);

      // R7: latency of one clock after the write edge
      @(negedge clk);
      cfg_wr = 1'b1; cfg_off = 8'h59; cfg_len = 3'd1; cfg_wdata = 32'h20;
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R7 old value after write edge", 32'(hi_attr), 1);
      @(negedge clk);
      chk("R7 new value one clock later", 32'(hi_attr), 2);

      // R1: unsupported length writes nothing
      cfg_write(8'h59, 3'd3, 32'h30);
      @(negedge clk);
      chk("R1 length 3 ignored", 32'(hi_attr), 2);

      // R9 / R6: neighbouring offsets have no effect
      cfg_write(8'h60, 3'd1, 32'hFF);
      cfg_write(8'h71, 3'd1, 32'hFF);
      cfg_write(8'h73, 3'd1, 32'hFF);
      @(negedge clk);
      chk("R9 seg_attr after off-map writes", 32'(seg_attr), 32'h00E4_325A);
      chk("R6 smram_vis after adjacent writes", 32'(smram_vis), 1);

      // R6: write at 0x5F straddling into 0x60 recomputes
      cfg_write(8'h5F, 3'd2, 32'hFFFF_FF00);
      @(negedge clk);
      look("R6 straddle at 0x5F", 32'h000E_8000, 2'd0);

      // R5 / R7: SMM-gated visibility
      cfg_write(8'h72, 3'd1, 32'h08);
      @(negedge clk);
      chk("R5 gate bit without SMM", 32'(smram_vis), 0);
      smm_active = 1'b1;
      @(negedge clk);
      chk("R7 SMM rise not yet visible", 32'(smram_vis), 0);
      @(negedge clk);
      chk("R5 gate bit with SMM", 32'(smram_vis), 1);
      cfg_write(8'h72, 3'd1, 32'h00);
      @(negedge clk);
      chk("R5 SMM without gate bit", 32'(smram_vis), 0);
      cfg_write(8'h72, 3'd1, 32'h08);
      @(negedge clk);
      chk("R5 gate restored", 32'(smram_vis), 1);
      smm_active = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R7 SMM fall recomputes", 32'(smram_vis), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule